// File: doc/BRIEF.md
# Region-Based Memory Wait-State Controller

This block sits between a processor core and its external memory bus and sets the length of every external read or write. When a request arrives, the block looks up a wait-state count for the target address. A program-space access always uses the single program wait field. A data-space access uses one of five per-region data fields, and the top of data space always runs with zero waits. The block then drives an active-low read or write strobe that stays low for one base cycle plus that many extra cycles.

The wait fields are written through two configuration write ports. One port carries the five data-region fields together with a ROM-enable flag. The other port carries the program field. Every wait field comes out of reset at the maximum of seven, so a cold start is safe with slow memory. The ROM-enable flag resets high only when both mode inputs are high. The requester holds a level request and sees `busy` during the access and a one-cycle `done` when the access ends.

Top module: `memwait_ctrl`

## Requirements
- R1: While and after reset, `rd_n` and `wr_n` are 1 and `busy` and `done` are 0. Every wait field resets to 7, so any access to a waited region keeps the strobe low for 8 cycles. `rom_en` resets to `map_sel & boot_sel`.
- R2: A request is accepted on a clock edge where the controller is idle and `req` is 1. The strobe goes low in the cycle that follows that edge. `req_wr`=0 selects `rd_n` and `req_wr`=1 selects `wr_n`. The other strobe stays 1.
- R3: The strobe stays low for exactly (1 + wait count) cycles. `done` is 1 for exactly one cycle, starting in the cycle where the strobe returns to 1.
- R4: When `req_pm`=1, the wait count is the program field, whatever the address.
- R5: When `req_pm`=0, the data field is chosen by address range: field 0 for 0x0000-0x03FF, field 1 for 0x0400-0x07FF, field 2 for 0x0800-0x2FFF, field 3 for 0x3000-0x33FF, field 4 for 0x3400-0x37FF.
- R6: Data accesses at 0x3800 and above use zero wait states, so the strobe is low for 1 cycle.
- R7: A write on `dcfg_we` loads data field k from `dcfg_wdata[3k+2:3k]` for k = 0 to 4, and loads `rom_en` from `dcfg_wdata[15]`. Without a write, `rom_en` holds its value.
- R8: A write on `pcfg_we` loads the program field from `pcfg_wdata[2:0]`.
- R9: A request seen while `busy` is 1 is ignored and starts no access. A request held high through an access is accepted on the first edge after the `done` cycle.
- R10: `mem_addr` equals the accepted request address and holds steady for the whole access, even if `req_addr` changes.
- R11: The wait count is captured at acceptance. A configuration write during an access does not change that access's strobe length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_sel | input | 1 | Memory-map mode input, used at reset |
| boot_sel | input | 1 | Boot mode input, used at reset |
| dcfg_we | input | 1 | Write enable for the data-region field word |
| dcfg_wdata | input | 16 | Data fields in [14:0], ROM enable in [15] |
| pcfg_we | input | 1 | Write enable for the program field |
| pcfg_wdata | input | 3 | Program wait count |
| req | input | 1 | Access request (level) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_pm | input | 1 | 1 = program space, 0 = data space |
| req_addr | input | 14 | Access address |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| mem_addr | output | 14 | Registered address held for the access |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rom_en | output | 1 | ROM-enable flag |

## Verification
The bench probes the first and last address of every data region. An off-by-one boundary compare would give the neighbouring region's count and a wrong strobe length. It sends a request pulse while an access is running; a controller that queued requests would produce a second strobe. It also rewrites a field in the middle of an access, which exposes a design that reads the live field instead of a captured count. Directed checks after reset confirm the seven-wait default and the mode-dependent ROM flag, since a wrong reset constant would shorten the first accesses.

// File: rtl/memwait_pkg.sv
package memwait_pkg;
  localparam int ADDR_W   = 14;
  localparam int WAIT_W   = 3;
  localparam int NUM_DREG = 5;
  // exclusive upper bound of each waited data region, ascending
  localparam logic [ADDR_W-1:0] DM_BOUND [NUM_DREG] =
    '{14'h0400, 14'h0800, 14'h3000, 14'h3400, 14'h3800};

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_DONE} seq_state_e;
endpackage

// File: rtl/memwait_regs.sv
module memwait_regs
  import memwait_pkg::*;
#(
  parameter int WAIT_W_P = WAIT_W,
  parameter int NDREG_P  = NUM_DREG,
  localparam int DF_W    = NDREG_P * WAIT_W_P,
  localparam int CFG_W   = DF_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                map_sel,
  input  logic                boot_sel,
  input  logic                dcfg_we,
  input  logic [CFG_W-1:0]    dcfg_wdata,
  input  logic                pcfg_we,
  input  logic [WAIT_W_P-1:0] pcfg_wdata,
  output logic [WAIT_W_P-1:0] pwait,
  output logic [DF_W-1:0]     dwait,
  output logic                rom_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwait  <= '1;
      dwait  <= '1;
      rom_en <= map_sel & boot_sel;
    end else begin
      if (pcfg_we) pwait <= pcfg_wdata;
      if (dcfg_we) begin
        dwait  <= dcfg_wdata[DF_W-1:0];
        rom_en <= dcfg_wdata[CFG_W-1];
      end
    end
  end

  AST_ROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dcfg_we |=> $stable(rom_en)); // R7
endmodule

// File: rtl/memwait_decode.sv
module memwait_decode
  import memwait_pkg::*;
#(
  parameter int WAIT_W_P = WAIT_W,
  parameter int NDREG_P  = NUM_DREG,
  localparam int DF_W    = NDREG_P * WAIT_W_P
) (
  input  logic                req_pm,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WAIT_W_P-1:0] pwait,
  input  logic [DF_W-1:0]     dwait,
  output logic [WAIT_W_P-1:0] wsel
);
  always_comb begin
    wsel = '0;
    if (req_pm) begin
      wsel = pwait;
    end else begin
      // walk downward so the lowest matching region wins
      for (int k = NDREG_P - 1; k >= 0; k--) begin
        if (req_addr < DM_BOUND[k]) wsel = dwait[k*WAIT_W_P +: WAIT_W_P];
      end
    end
  end
endmodule

// File: rtl/memwait_seq.sv
module memwait_seq
  import memwait_pkg::*;
#(
  parameter int WAIT_W_P = WAIT_W,
  localparam int RUN_W   = WAIT_W_P + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                req_wr,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WAIT_W_P-1:0] wsel,
  output logic                rd_n,
  output logic                wr_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                busy,
  output logic                done
);
  seq_state_e          state;
  logic [WAIT_W_P-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      mem_addr <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          done <= 1'b0;
          if (req) begin
            state    <= ST_STROBE;
            cnt      <= wsel;
            mem_addr <= req_addr;
            rd_n     <= req_wr;
            wr_n     <= ~req_wr;
            busy     <= 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_DONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          done  <= 1'b0;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // run-length monitor for the strobe
  logic             strb_low;
  logic [RUN_W-1:0] run;
  assign strb_low = ~rd_n | ~wr_n;
  always_ff @(posedge clk) begin
    if (rst)           run <= '0;
    else if (strb_low) run <= run + 1'b1;
    else               run <= '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_n && wr_n)); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (strb_low && $past(strb_low)) |-> $stable(mem_addr)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n && $past(strb_low))); // R3
  AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (rst)
    strb_low |-> (run < RUN_W'(1 << WAIT_W_P))); // R3
endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
  import memwait_pkg::*;
#(
  parameter int WAIT_W_P = WAIT_W,
  parameter int NDREG_P  = NUM_DREG,
  localparam int DF_W    = NDREG_P * WAIT_W_P,
  localparam int CFG_W   = DF_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                map_sel,
  input  logic                boot_sel,
  input  logic                dcfg_we,
  input  logic [CFG_W-1:0]    dcfg_wdata,
  input  logic                pcfg_we,
  input  logic [WAIT_W_P-1:0] pcfg_wdata,
  input  logic                req,
  input  logic                req_wr,
  input  logic                req_pm,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rd_n,
  output logic                wr_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                busy,
  output logic                done,
  output logic                rom_en
);
  logic [WAIT_W_P-1:0] pwait;
  logic [DF_W-1:0]     dwait;
  logic [WAIT_W_P-1:0] wsel;

  memwait_regs #(.WAIT_W_P(WAIT_W_P), .NDREG_P(NDREG_P)) u_regs (
    .clk(clk), .rst(rst), .map_sel(map_sel), .boot_sel(boot_sel),
    .dcfg_we(dcfg_we), .dcfg_wdata(dcfg_wdata),
    .pcfg_we(pcfg_we), .pcfg_wdata(pcfg_wdata),
    .pwait(pwait), .dwait(dwait), .rom_en(rom_en)
  );

  memwait_decode #(.WAIT_W_P(WAIT_W_P), .NDREG_P(NDREG_P)) u_dec (
    .req_pm(req_pm), .req_addr(req_addr),
    .pwait(pwait), .dwait(dwait), .wsel(wsel)
  );

  memwait_seq #(.WAIT_W_P(WAIT_W_P)) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .wsel(wsel), .rd_n(rd_n), .wr_n(wr_n), .mem_addr(mem_addr),
    .busy(busy), .done(done)
  );
endmodule

// File: tb/memwait_ctrl_test.sv
module memwait_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_sel = 1'b1, boot_sel = 1'b1;
  logic        dcfg_we = 1'b0;
  logic [15:0] dcfg_wdata = '0;
  logic        pcfg_we = 1'b0;
  logic [2:0]  pcfg_wdata = '0;
  logic        req = 1'b0, req_wr = 1'b0, req_pm = 1'b0;
  logic [13:0] req_addr = '0;
  logic        rd_n, wr_n, busy, done, rom_en;
  logic [13:0] mem_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  memwait_ctrl uut (
    .clk(clk), .rst(rst), .map_sel(map_sel), .boot_sel(boot_sel),
    .dcfg_we(dcfg_we), .dcfg_wdata(dcfg_wdata),
    .pcfg_we(pcfg_we), .pcfg_wdata(pcfg_wdata),
    .req(req), .req_wr(req_wr), .req_pm(req_pm), .req_addr(req_addr),
    .rd_n(rd_n), .wr_n(wr_n), .mem_addr(mem_addr),
    .busy(busy), .done(done), .rom_en(rom_en)
  );

  // {pm, wr, addr, expected wait} with d0..d4 = 1,2,3,4,6 and program = 5
  localparam logic [19:0] VEC [14] = '{
    {1'b0, 1'b0, 14'h0000, 4'd1}, {1'b0, 1'b1, 14'h03FF, 4'd1},
    {1'b0, 1'b0, 14'h0400, 4'd2}, {1'b0, 1'b1, 14'h07FF, 4'd2},
    {1'b0, 1'b0, 14'h0800, 4'd3}, {1'b0, 1'b0, 14'h2FFF, 4'd3},
    {1'b0, 1'b1, 14'h3000, 4'd4}, {1'b0, 1'b0, 14'h33FF, 4'd4},
    {1'b0, 1'b0, 14'h3400, 4'd6}, {1'b0, 1'b1, 14'h37FF, 4'd6},
    {1'b0, 1'b0, 14'h3800, 4'd0}, {1'b0, 1'b1, 14'h3FFF, 4'd0},
    {1'b1, 1'b0, 14'h0000, 4'd5}, {1'b1, 1'b1, 14'h3FFF, 4'd5}
  };

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // drive a request for one accept edge; return at the first sample point after acceptance
  task automatic launch(input logic pm, input logic wr, input logic [13:0] a);
    @(negedge clk);
    req_pm = pm; req_wr = wr; req_addr = a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  // called at the first negedge after acceptance
  task automatic measure(input logic wr, input logic [13:0] a, input int expw, input string rq);
    int n = 0;
    logic sel, oth;
    sel = wr ? wr_n : rd_n;
    chk(sel == 1'b0, "R2", int'(sel), 0);
    while (((wr ? wr_n : rd_n) == 1'b0) && n < 20) begin
      n++;
      oth = wr ? rd_n : wr_n;
      if (oth != 1'b1) chk(1'b0, "R2", int'(oth), 1);
      if (mem_addr != a) chk(1'b0, "R10", int'(mem_addr), int'(a));
      @(negedge clk);
    end
    chk(n == expw + 1, rq, n, expw + 1);
    chk(done == 1'b1, "R3", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R3", int'({done, busy}), 0);
  endtask

  initial begin
    // R1: reset state with both mode inputs high
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_n && wr_n && !busy && !done, "R1", int'({rd_n, wr_n, busy, done}), 12);
    rst = 1'b0;
    @(negedge clk);
    chk(rom_en == 1'b1, "R1", int'(rom_en), 1);
    chk(rd_n && wr_n && !busy && !done, "R1", int'({rd_n, wr_n, busy, done}), 12);
    launch(1'b0, 1'b0, 14'h0000); measure(1'b0, 14'h0000, 7, "R1");
    launch(1'b1, 1'b1, 14'h0100); measure(1'b1, 14'h0100, 7, "R1");
    launch(1'b0, 1'b0, 14'h3400); measure(1'b0, 14'h3400, 7, "R1");
    launch(1'b0, 1'b1, 14'h3900); measure(1'b1, 14'h3900, 0, "R6");

    // R1: reset again with only one mode input high
    @(negedge clk); rst = 1'b1; boot_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rom_en == 1'b0, "R1", int'(rom_en), 0);

    // R7, R8: program both configuration words
    pcfg_we = 1'b1; pcfg_wdata = 3'd5;
    dcfg_we = 1'b1; dcfg_wdata = 16'hE8D1;
    @(negedge clk);
    pcfg_we = 1'b0; dcfg_we = 1'b0;
    chk(rom_en == 1'b1, "R7", int'(rom_en), 1);

    // R4 R5 R6 R8: table walk
    for (int i = 0; i < 14; i++) begin
      launch(VEC[i][19], VEC[i][18], VEC[i][17:4]);
      measure(VEC[i][18], VEC[i][17:4], int'(VEC[i][3:0]),
              VEC[i][19] ? "R4" : (VEC[i][3:0] == 0 ? "R6" : "R5"));
    end

    // R9: a pulse during an access is dropped
    begin
      int lows = 0;
      @(negedge clk);
      req_pm = 1'b0; req_wr = 1'b0; req_addr = 14'h0000; req = 1'b1;
      @(negedge clk);
      req_addr = 14'h3800;
      @(negedge clk);
      req = 1'b0;
      lows = 2;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!rd_n) lows++;
      end
      chk(lows == 2, "R9", lows, 2);
      chk(busy == 1'b0, "R9", int'(busy), 0);
      chk(mem_addr == 14'h0000, "R9", int'(mem_addr), 0);
    end

    // R9 R10: request held through an access, address changed mid-way
    @(negedge clk);
    req_pm = 1'b0; req_wr = 1'b0; req_addr = 14'h0400; req = 1'b1;
    @(negedge clk);
    req_wr = 1'b1; req_addr = 14'h3000;
    measure(1'b0, 14'h0400, 2, "R10");
    @(negedge clk);
    req = 1'b0;
    measure(1'b1, 14'h3000, 4, "R9");

    // R11: field rewrite during an access; d1 becomes 7, rom flag cleared
    launch(1'b0, 1'b0, 14'h0400);
    dcfg_we = 1'b1; dcfg_wdata = 16'h68F9;
    measure(1'b0, 14'h0400, 2, "R11");
    dcfg_we = 1'b0;
    chk(rom_en == 1'b0, "R7", int'(rom_en), 0);
    launch(1'b0, 1'b0, 14'h07FF); measure(1'b0, 14'h07FF, 7, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule